// File: doc/BRIEF.md
# Incrementing valid-ready register stage

This block is one registered step in a streaming datapath. A producer offers words with a valid/ready handshake. A consumer takes the results with a second valid/ready handshake. When the stage accepts a word, it adds a fixed constant to it (by default one, modulo the word width). It holds the sum in an output register and presents that register to the consumer on the next cycle.

The ready that the stage gives the producer comes from a flop. It repeats the consumer's ready as it was one cycle earlier, so no combinational path runs from the consumer's ready to the producer. This cuts the timing path. The cost is a one-cycle-late view of backpressure. If a word is accepted while the consumer is stalling an older word, the new word replaces the older one. A lossless system therefore keeps its producer from offering while the output is valid and the consumer's ready is low.

Top module: `vr_incr_stage`

## Requirements
- R1: While rst_n is low, out_vld and in_rdy are 0 and out_data is all zeros.
- R2: After each rising clock edge outside reset, in_rdy equals the value out_rdy had at that edge.
- R3: An accept is an edge at which in_vld and in_rdy are both 1. After an accept, out_vld is 1.
- R4: After an accept, out_data equals in_data from that edge plus INC, taken modulo 2^WIDTH.
- R5: At an edge with no accept, out_vld 1 and out_rdy 0, the stage keeps presenting the stalled word: out_vld stays 1 and out_data is unchanged.
- R6: At an edge with no accept and with out_rdy 1 or out_vld 0, out_vld becomes 0.
- R7: At any edge with no accept, out_data keeps its value, whatever the state of out_rdy.
- R8: An accept while a stalled word is still presented replaces that word: out_data takes the new sum and out_vld stays 1.
- R9: An all-ones input word with INC of 1 produces an all-zeros output word.
- R10: Suppose the producer offers only in cycles where out_rdy is 1 or out_vld is 0. Then every accepted word reaches the consumer exactly once and in order, as its input plus INC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_vld | input | 1 | Producer has a word on in_data |
| in_rdy | output | 1 | Stage will accept a word at the next edge (registered copy of out_rdy) |
| in_data | input | WIDTH | Word offered by the producer |
| out_vld | output | 1 | out_data holds a word for the consumer |
| out_rdy | input | 1 | Consumer takes the presented word at this edge |
| out_data | output | WIDTH | Transformed word held in the output register |

## Verification
The bench builds the stage with its defaults: WIDTH of 16 and INC of 1. At that width the carry wrap from 0xFFFF to zero can be driven directly, and random input words cover the full range. Directed scenarios cover the ready delay, stall hold, drain and the overwrite that follows a late ready drop. A long random run then uses a rule-abiding producer and independently drawn consumer ready, and matches every delivered word against a queue of expected sums.

// File: rtl/vr_incr_stage_pkg.sv
package vr_incr_stage_pkg;

  // Next-state bundle of the handshake control flops.
  typedef struct packed {
    logic vld;
    logic rdy;
  } hs_state_t;

  localparam hs_state_t HS_RESET = '{vld: 1'b0, rdy: 1'b0};

endpackage

// File: rtl/vr_xform.sv
// Fixed combinational transform: add a constant, wrapping at the word width.
module vr_xform #(
  parameter int WIDTH = 16,
  parameter int INC   = 1
) (
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam logic [WIDTH-1:0] INC_W = WIDTH'(INC);

  generate
    if (INC == 0) begin : g_pass
      assign dout = din;
    end else begin : g_add
      assign dout = din + INC_W;
    end
  endgenerate

endmodule

// File: rtl/vr_stage_ctrl.sv
// Handshake control: registered upstream ready and output valid.
module vr_stage_ctrl
  import vr_incr_stage_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_vld,
  input  logic out_rdy,
  output logic in_rdy,
  output logic out_vld,
  output logic accept
);

  hs_state_t st_q;
  hs_state_t st_d;

  assign in_rdy  = st_q.rdy;
  assign out_vld = st_q.vld;
  assign accept  = in_vld & st_q.rdy;

  always_comb begin
    st_d     = st_q;
    st_d.rdy = out_rdy;
    if (accept) begin
      st_d.vld = 1'b1;
    end else begin
      st_d.vld = st_q.vld & ~out_rdy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= HS_RESET;
    end else begin
      st_q <= st_d;
    end
  end

endmodule

// File: rtl/vr_stage_dreg.sv
// Output data register with an explicit load enable.
module vr_stage_dreg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load) begin
      q_d = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_d;
    end
  end

endmodule

// File: rtl/vr_incr_stage.sv
// Registered valid-ready stage applying a constant increment.
module vr_incr_stage #(
  parameter int WIDTH = 16,
  parameter int INC   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  output logic             in_rdy,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_vld,
  input  logic             out_rdy,
  output logic [WIDTH-1:0] out_data
);

  logic             accept;
  logic [WIDTH-1:0] xf_data;

  vr_stage_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .out_rdy (out_rdy),
    .in_rdy  (in_rdy),
    .out_vld (out_vld),
    .accept  (accept)
  );

  vr_xform #(
    .WIDTH (WIDTH),
    .INC   (INC)
  ) u_xform (
    .din  (in_data),
    .dout (xf_data)
  );

  vr_stage_dreg #(
    .WIDTH (WIDTH)
  ) u_dreg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .d     (xf_data),
    .q     (out_data)
  );

endmodule

// File: rtl/vr_incr_stage_chk.sv
// Protocol checker for vr_incr_stage, attached through bind.
module vr_incr_stage_chk #(
  parameter int WIDTH = 16,
  parameter int INC   = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_vld,
  input logic             in_rdy,
  input logic [WIDTH-1:0] in_data,
  input logic             out_vld,
  input logic             out_rdy,
  input logic [WIDTH-1:0] out_data
);

  localparam logic [WIDTH-1:0] INC_W = WIDTH'(INC);

  logic acc;
  assign acc = in_vld & in_rdy;

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |-> (!out_vld && !in_rdy));

  p_ready_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (in_rdy == $past(out_rdy)));

  p_accept_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_vld);

  p_accept_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (out_data == WIDTH'($past(in_data) + INC_W)));

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && out_vld && !out_rdy) |=> (out_vld && $stable(out_data)));

  p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && (out_rdy || !out_vld)) |=> !out_vld);

  p_data_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(out_data));

endmodule

bind vr_incr_stage vr_incr_stage_chk #(
  .WIDTH (WIDTH),
  .INC   (INC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_vld   (in_vld),
  .in_rdy   (in_rdy),
  .in_data  (in_data),
  .out_vld  (out_vld),
  .out_rdy  (out_rdy),
  .out_data (out_data)
);

// File: tb/vr_incr_stage_tb.sv
`timescale 1ns/1ps
module vr_incr_stage_tb;

  localparam int WIDTH = 16;
  localparam int INC   = 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b1;
  logic             in_vld = 1'b0;
  logic             in_rdy;
  logic [WIDTH-1:0] in_data = '0;
  logic             out_vld;
  logic             out_rdy = 1'b0;
  logic [WIDTH-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  vr_incr_stage #(.WIDTH(WIDTH), .INC(INC)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_rdy(in_rdy),
    .in_data(in_data), .out_vld(out_vld), .out_rdy(out_rdy),
    .out_data(out_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One clock, then sample 1 ns after the edge.
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    out_rdy = 1'b1; in_vld = 1'b1; in_data = 16'h0042;
    repeat (3) step();
    chk("R1", "out_vld in reset", 32'(out_vld), 32'd0);
    chk("R1", "in_rdy in reset", 32'(in_rdy), 32'd0);
    chk("R1", "out_data in reset", 32'(out_data), 32'd0);
    in_vld = 1'b0; out_rdy = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_ready_follow();
    logic pat [5] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    in_vld = 1'b0;
    foreach (pat[i]) begin
      out_rdy = pat[i];
      step();
      chk("R2", "in_rdy follows out_rdy", 32'(in_rdy), 32'(pat[i]));
    end
  endtask

  task automatic t_accept();
    out_rdy = 1'b1; in_vld = 1'b0;
    step();
    in_vld = 1'b1; in_data = 16'h1234;
    step();
    chk("R3", "out_vld after accept", 32'(out_vld), 32'd1);
    chk("R4", "out_data after accept", 32'(out_data), 32'h1235);
  endtask

  task automatic t_stall();
    out_rdy = 1'b0; in_vld = 1'b0;
    step();
    chk("R5", "out_vld held while stalled", 32'(out_vld), 32'd1);
    chk("R5", "out_data held while stalled", 32'(out_data), 32'h1235);
    in_vld = 1'b1; in_data = 16'h0777;
    step();
    chk("R5", "out_vld held, no accept", 32'(out_vld), 32'd1);
    chk("R7", "out_data ignores blocked offer", 32'(out_data), 32'h1235);
  endtask

  task automatic t_drain();
    in_vld = 1'b0; out_rdy = 1'b1;
    step();
    chk("R6", "out_vld clears on take", 32'(out_vld), 32'd0);
    chk("R7", "out_data kept after take", 32'(out_data), 32'h1235);
    step();
    chk("R6", "out_vld stays 0 idle", 32'(out_vld), 32'd0);
    chk("R7", "out_data kept idle", 32'(out_data), 32'h1235);
  endtask

  task automatic t_wrap();
    out_rdy = 1'b1; in_vld = 1'b1; in_data = 16'hFFFF;
    step();
    chk("R9", "wrap out_data", 32'(out_data), 32'h0000);
    chk("R9", "wrap out_vld", 32'(out_vld), 32'd1);
    in_vld = 1'b0;
    step();
  endtask

  task automatic t_overwrite();
    out_rdy = 1'b1; in_vld = 1'b1; in_data = 16'h00A0;
    step();
    chk("R4", "first word", 32'(out_data), 32'h00A1);
    out_rdy = 1'b0; in_data = 16'h00B0;
    step();
    chk("R8", "overwrite out_data", 32'(out_data), 32'h00B1);
    chk("R8", "overwrite out_vld", 32'(out_vld), 32'd1);
    chk("R2", "in_rdy low after drop", 32'(in_rdy), 32'd0);
    in_vld = 1'b0; out_rdy = 1'b1;
    step();
    step();
  endtask

  task automatic t_stream();
    logic [WIDTH-1:0] q [$];
    int sent = 0;
    int got  = 0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (cyc < 2900) begin
        out_rdy = ($urandom_range(0, 3) != 0);
        in_vld  = ($urandom_range(0, 1) == 1) && (out_rdy || !out_vld);
        in_data = WIDTH'($urandom);
      end else begin
        out_rdy = 1'b1;
        in_vld  = 1'b0;
      end
      if (out_vld && out_rdy) begin
        got++;
        if (q.size() == 0) begin
          chk("R10", "unexpected extra word", 32'(out_data), 32'hFFFF_FFFF);
        end else begin
          chk("R10", "stream word", 32'(out_data), 32'(q.pop_front()));
        end
      end
      if (in_vld && in_rdy) begin
        q.push_back(in_data + WIDTH'(INC));
        sent++;
      end
      step();
    end
    chk("R10", "words left undelivered", 32'(q.size()), 32'd0);
    chk("R10", "delivered count", 32'(got), 32'(sent));
  endtask

  initial begin
    #1;
    t_reset();
    t_ready_follow();
    t_accept();
    t_stall();
    t_drain();
    t_wrap();
    t_overwrite();
    t_stream();
    finish_run();
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

endmodule